// File: doc/BRIEF.md
# Lagging Thread Identifier

This block watches the instruction commit stream of a group of hardware threads that run the same parallel program between barriers. Each thread owns a saturating progress counter that advances by one for every committed instruction; a barrier-release pulse returns every counter to zero, since all threads are expected to commit equal work between barriers.

When a scheduling quantum ends, the block freezes a copy of all counters, the thread enable mask and the margin. It then walks the copy one thread per cycle to find the smallest progress among enabled threads, and finally marks every enabled thread whose progress lies strictly below that minimum plus the margin. The resulting bitmask and the number of marked threads are presented together with a one-cycle done pulse. They stay unchanged until the next evaluation finishes. A downstream scheduler uses the mask to pick acceleration candidates and the count as the divisor of the global benefit term.

Top module: `lag_thread_finder`

## Requirements
- R1: After reset the lagging mask, the lagging count and the done pulse are all zero, and every progress counter is zero.
- R2: A high commit bit for thread t in a cycle adds one to that thread's counter; a counter at its all-ones value stays there.
- R3: A barrier-clear pulse sets every counter to zero and wins over commits sampled in the same cycle.
- R4: A quantum-end strobe sampled while no evaluation is running freezes the counters, the enable mask and the margin; done pulses high, with the new mask and count, N_THREADS+1 cycles after that sampling edge.
- R5: With minP the smallest frozen progress among enabled threads, bit t of the mask is one exactly when thread t is enabled and its progress is below minP + margin, the sum taken without wrap-around.
- R6: A margin of zero yields an empty mask and a count of zero.
- R7: A thread whose enable bit is zero takes no part in the minimum and is never marked; with no thread enabled the mask and count are zero.
- R8: The count equals the number of ones in the mask, and both change in the same cycle.
- R9: Mask and count stay constant between done pulses, and a quantum-end strobe that arrives while an evaluation runs is ignored.
- R10: Commits, enable or margin changes after the freezing edge do not change the running evaluation, but the commits are counted for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | N_THREADS | One bit per thread, high for one committed instruction |
| barrier_clr_i | input | 1 | Clears all progress counters |
| margin_i | input | CNT_W | Progress margin added to the minimum |
| thread_en_i | input | N_THREADS | Threads taking part in the evaluation |
| quantum_end_i | input | 1 | Starts an evaluation |
| lag_mask_o | output | N_THREADS | Lagging threads of the last evaluation |
| lag_count_o | output | clog2(N_THREADS+1) | Number of lagging threads |
| eval_done_o | output | 1 | One-cycle pulse when mask and count update |

## Verification
Progress profiles with distinct values tell a correct minimum from an off-by-one threshold, since one thread sits just below and one exactly at minP + margin. A zero margin, a margin that pushes the threshold past the counter range, and a saturated counter separate strict from non-strict comparison, wrap-around sums and free-running counters. Partial and empty enable masks show disabled threads dropping out of the minimum as well as the mask, and a barrier pulse coinciding with a commit shows clear priority. A second strobe and commits inside a running evaluation show that the frozen copy alone decides the result and that no extra done pulse appears.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_SCAN = 2'd1,
    EV_LOAD = 2'd2
  } ev_state_e;
endpackage

// File: rtl/lt_progress_bank.sv
module lt_progress_bank #(
  parameter int N_THREADS = 8,
  parameter int CNT_W     = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_THREADS-1:0]                inc_i,
  input  logic                                clr_i,
  output logic [N_THREADS-1:0][CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar t = 0; t < N_THREADS; t++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt_o[t] <= '0;
      else if (clr_i)                             cnt_o[t] <= '0;
      else if (inc_i[t] && (cnt_o[t] != CNT_MAX)) cnt_o[t] <= cnt_o[t] + 1'b1;
    end
  end
endmodule

// File: rtl/lt_min_scan.sv
module lt_min_scan #(
  parameter int N_THREADS = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             step_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0]  snap_i,
  input  logic [N_THREADS-1:0]             en_i,
  output logic [CNT_W-1:0]                 min_o,
  output logic                             any_o
);
  logic [CNT_W-1:0] cur;
  logic             cur_en;

  assign cur    = snap_i[idx_i];
  assign cur_en = en_i[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_o <= '1;
      any_o <= 1'b0;
    end else if (clr_i) begin
      min_o <= '1;
      any_o <= 1'b0;
    end else if (step_i && cur_en && (!any_o || (cur < min_o))) begin
      min_o <= cur;
      any_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lt_classifier.sv
module lt_classifier #(
  parameter int N_THREADS = 8,
  parameter int CNT_W     = 16,
  localparam int CNT_CW   = $clog2(N_THREADS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0]  snap_i,
  input  logic [N_THREADS-1:0]             en_i,
  input  logic [CNT_W-1:0]                 min_i,
  input  logic                             any_i,
  input  logic [CNT_W-1:0]                 margin_i,
  output logic [N_THREADS-1:0]             mask_o,
  output logic [CNT_CW-1:0]                count_o,
  output logic                             done_o
);
  logic [CNT_W:0]          thresh;
  logic [N_THREADS-1:0]    mask_d;
  logic [CNT_CW-1:0]       count_d;

  // one extra bit so minimum plus margin never wraps
  assign thresh = {1'b0, min_i} + {1'b0, margin_i};

  always_comb begin
    mask_d  = '0;
    count_d = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      mask_d[t] = any_i && en_i[t] && ({1'b0, snap_i[t]} < thresh);
      count_d   = count_d + CNT_CW'(mask_d[t]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        mask_o  <= mask_d;
        count_o <= count_d;
      end
    end
  end
endmodule

// File: rtl/lag_thread_finder.sv
module lag_thread_finder #(
  parameter int N_THREADS = 8,
  parameter int CNT_W     = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_THREADS-1:0]               commit_i,
  input  logic                               barrier_clr_i,
  input  logic [CNT_W-1:0]                   margin_i,
  input  logic [N_THREADS-1:0]               thread_en_i,
  input  logic                               quantum_end_i,
  output logic [N_THREADS-1:0]               lag_mask_o,
  output logic [$clog2(N_THREADS+1)-1:0]     lag_count_o,
  output logic                               eval_done_o
);
  import lt_pkg::*;

  localparam int IDX_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_THREADS - 1);

  ev_state_e                        state_q;
  logic [IDX_W-1:0]                 idx_q;
  logic [N_THREADS-1:0][CNT_W-1:0]  prog;
  logic [N_THREADS-1:0][CNT_W-1:0]  snap_q;
  logic [N_THREADS-1:0]             en_snap_q;
  logic [CNT_W-1:0]                 margin_snap_q;
  logic [CNT_W-1:0]                 min_val;
  logic                             min_any;
  logic                             start;
  logic                             scan_step;
  logic                             cls_load;

  assign start     = (state_q == EV_IDLE) && quantum_end_i;
  assign scan_step = (state_q == EV_SCAN);
  assign cls_load  = (state_q == EV_LOAD);

  lt_progress_bank #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (commit_i),
    .clr_i  (barrier_clr_i),
    .cnt_o  (prog)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= EV_IDLE;
      idx_q         <= '0;
      snap_q        <= '0;
      en_snap_q     <= '0;
      margin_snap_q <= '0;
    end else begin
      unique case (state_q)
        EV_IDLE: if (quantum_end_i) begin
          snap_q        <= prog;
          en_snap_q     <= thread_en_i;
          margin_snap_q <= margin_i;
          idx_q         <= '0;
          state_q       <= EV_SCAN;
        end
        EV_SCAN: begin
          if (idx_q == IDX_LAST) state_q <= EV_LOAD;
          else                   idx_q   <= idx_q + 1'b1;
        end
        EV_LOAD: state_q <= EV_IDLE;
        default: state_q <= EV_IDLE;
      endcase
    end
  end

  lt_min_scan #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) scan_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .step_i (scan_step),
    .idx_i  (idx_q),
    .snap_i (snap_q),
    .en_i   (en_snap_q),
    .min_o  (min_val),
    .any_o  (min_any)
  );

  lt_classifier #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) cls_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cls_load),
    .snap_i   (snap_q),
    .en_i     (en_snap_q),
    .min_i    (min_val),
    .any_i    (min_any),
    .margin_i (margin_snap_q),
    .mask_o   (lag_mask_o),
    .count_o  (lag_count_o),
    .done_o   (eval_done_o)
  );
endmodule

// File: rtl/lag_thread_finder_chk.sv
module lag_thread_finder_chk #(
  parameter int N_THREADS = 8,
  parameter int CNT_W     = 16
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [N_THREADS-1:0]               commit_i,
  input logic                               barrier_clr_i,
  input logic [N_THREADS-1:0][CNT_W-1:0]    prog,
  input logic [N_THREADS-1:0]               en_snap,
  input logic [CNT_W-1:0]                   margin_snap,
  input logic [N_THREADS-1:0]               lag_mask_o,
  input logic [$clog2(N_THREADS+1)-1:0]     lag_count_o,
  input logic                               eval_done_o
);
  // R3
  barrier_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    barrier_clr_i |=> (prog == '0));

  // R2
  counter_saturates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog[0] == {CNT_W{1'b1}} && commit_i[0] && !barrier_clr_i) |=> (prog[0] == {CNT_W{1'b1}}));

  // R7
  mask_within_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_done_o |-> ((lag_mask_o & ~en_snap) == '0));

  // R8
  count_matches_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lag_count_o == $bits(lag_count_o)'($countones(lag_mask_o)));

  // R5
  min_thread_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_done_o && (margin_snap != '0) && (en_snap != '0)) |-> (lag_count_o != '0));

  // R6
  zero_margin_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_done_o && (margin_snap == '0)) |-> (lag_mask_o == '0));

  // R9
  outputs_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_done_o |-> ($stable(lag_mask_o) && $stable(lag_count_o)));

  // R9
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_done_o |=> !eval_done_o);
endmodule

bind lag_thread_finder lag_thread_finder_chk #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .commit_i      (commit_i),
  .barrier_clr_i (barrier_clr_i),
  .prog          (prog),
  .en_snap       (en_snap_q),
  .margin_snap   (margin_snap_q),
  .lag_mask_o    (lag_mask_o),
  .lag_count_o   (lag_count_o),
  .eval_done_o   (eval_done_o)
);

// File: tb/lag_thread_finder_tb_top.sv
module lag_thread_finder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] commit = '0;
  logic          barrier_clr = 1'b0;
  logic [CW-1:0] margin = '0;
  logic [NT-1:0] thread_en = '0;
  logic          quantum_end = 1'b0;
  logic [NT-1:0] lag_mask;
  logic [2:0]    lag_count;
  logic          eval_done;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lag_thread_finder #(.N_THREADS(NT), .CNT_W(CW)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .commit_i      (commit),
    .barrier_clr_i (barrier_clr),
    .margin_i      (margin),
    .thread_en_i   (thread_en),
    .quantum_end_i (quantum_end),
    .lag_mask_o    (lag_mask),
    .lag_count_o   (lag_count),
    .eval_done_o   (eval_done)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [NT-1:0] v);
    int n = 0;
    for (int i = 0; i < NT; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic commit_vec(input logic [NT-1:0] v, input int n);
    commit = v;
    repeat (n) @(negedge clk);
    commit = '0;
  endtask

  task automatic run_eval(input logic [NT-1:0] en, input logic [CW-1:0] mg,
                          input logic [NT-1:0] exp_mask, input string req);
    int lat;
    thread_en   = en;
    margin      = mg;
    quantum_end = 1'b1;
    @(negedge clk);
    quantum_end = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!eval_done && lat < 20);
    chk(lat == NT + 1, "R4 latency", lat, NT + 1);
    chk(lag_mask == exp_mask, req, int'(lag_mask), int'(exp_mask));
    chk(int'(lag_count) == popc(exp_mask), "R8 count", int'(lag_count), popc(exp_mask));
  endtask

  task automatic t_reset;
    chk(lag_mask == '0, "R1 mask", int'(lag_mask), 0);
    chk(lag_count == '0, "R1 count", int'(lag_count), 0);
    chk(eval_done == 1'b0, "R1 done", int'(eval_done), 0);
    // all counters zero: every enabled thread is below 0+1
    run_eval(4'b1111, 6'd1, 4'b1111, "R1 counters zero");
  endtask

  task automatic t_basic;
    // progress t0=10 t1=4 t2=7 t3=5
    commit_vec(4'b1111, 4);
    commit_vec(4'b1101, 1);
    commit_vec(4'b0101, 2);
    commit_vec(4'b0001, 3);
    run_eval(4'b1111, 6'd2, 4'b1010, "R5 min plus margin");
    run_eval(4'b1111, 6'd0, 4'b0000, "R6 zero margin");
    run_eval(4'b1111, 6'd63, 4'b1111, "R5 no wrap");
    run_eval(4'b1101, 6'd2, 4'b1000, "R7 partial enable");
    run_eval(4'b0000, 6'd5, 4'b0000, "R7 none enabled");
  endtask

  task automatic t_barrier;
    commit_vec(4'b0001, 3);
    barrier_clr = 1'b1;
    commit      = 4'b0010;
    @(negedge clk);
    barrier_clr = 1'b0;
    commit      = '0;
    commit_vec(4'b0100, 3);
    // t0=0 t1=0 t2=3 t3=0
    run_eval(4'b1111, 6'd1, 4'b1011, "R3 barrier priority");
  endtask

  task automatic t_busy;
    int lat;
    logic [NT-1:0] held;
    thread_en   = 4'b1111;
    margin      = 6'd1;
    quantum_end = 1'b1;
    @(negedge clk);
    quantum_end = 1'b0;
    margin      = 6'd0;
    thread_en   = 4'b0001;
    commit      = 4'b0001;
    quantum_end = 1'b1;
    @(negedge clk);
    quantum_end = 1'b0;
    lat = 1;
    repeat (4) @(negedge clk);
    lat += 4;
    commit = '0;
    while (!eval_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == NT + 1, "R9 latency under strobe", lat, NT + 1);
    chk(lag_mask == 4'b1011, "R10 frozen inputs", int'(lag_mask), 4'b1011);
    held = lag_mask;
    lat = 0;
    repeat (NT + 4) begin
      @(negedge clk);
      if (eval_done) lat++;
    end
    chk(lat == 0, "R9 ignored strobe", lat, 0);
    chk(lag_mask == held, "R9 held", int'(lag_mask), int'(held));
    // t0 picked up 5 commits during the scan
    run_eval(4'b1111, 6'd1, 4'b1010, "R10 commits kept");
  endtask

  task automatic t_saturate;
    barrier_clr = 1'b1;
    @(negedge clk);
    barrier_clr = 1'b0;
    commit_vec(4'b0011, 62);
    commit_vec(4'b0001, 8);
    // t0 clamps at 63, t1=62: threshold 64
    run_eval(4'b0011, 6'd2, 4'b0011, "R2 saturation");
    run_eval(4'b0011, 6'd1, 4'b0010, "R2 count step");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_barrier();
    t_busy();
    t_saturate();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule